// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a single-port synchronous static RAM with a shared data bus. On every rising clock edge it registers the address, the three chip selects, the write controls, the write data and the sleep request. During the next cycle the registered operation is carried out against the array. A read places its word in an output register, so the data appears one full cycle after the operation is accepted. A write updates the selected lanes of the array during that same cycle.

The 36-bit word is made of four 9-bit lanes. Each lane holds eight data bits and one parity bit, and each lane can be written on its own. A global write stores the whole word no matter what the per-lane selects say. The bidirectional bus is modelled as a separate input word, an output word and a driver enable. The output enable input gates the driver enable combinationally. When a read comes straight after a deselected cycle, the driver is held off for that read so that banks placed side by side cannot both drive the bus. A sleep input stops writes and turns the driver off, and the stored contents are kept.

The address comes from an external burst address unit, and burst sequencing is not part of this block. The memory depth is set by the address-width parameter.

Top module: `pipe_sram`

## Requirements
- R1: All synchronous inputs are sampled on the rising edge. For a read accepted at edge N, the word is on `dq_o` after edge N+1 and stays there until the next read updates it.
- R2: Lane k occupies data bits [8k+7:8k] and parity bit 32+k of the 36-bit word.
- R3: With `bwr_en_i` high and `gwr_i` low, only the lanes whose `bsel_i[k]` bit is 1 are written, and the other lanes keep their contents. With `bsel_i` = 0000 nothing is written and no read takes place.
- R4: With `gwr_i` high, all four lanes are written, whatever the values of `bsel_i` and `bwr_en_i`.
- R5: A selected cycle with `gwr_i` and `bwr_en_i` both low is a read, and it leaves the array unchanged.
- R6: The block is selected only when `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. A deselected cycle neither reads nor writes, and `dq_o` holds its value.
- R7: `dq_oe_o` follows `oe_i` combinationally. It is low in the same time step whenever `oe_i` is low.
- R8: A read whose previously accepted cycle was not selected (deselected, asleep, or the first cycle after reset) does not drive the bus. `dq_oe_o` stays low for its output cycle. A read that directly follows a selected cycle drives the bus.
- R9: While `sleep_i` is high, writes presented to the block are ignored, `dq_oe_o` is low, and the stored contents are kept.
- R10: Synchronous reset clears the output register to zero and holds `dq_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address from the burst address unit |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| gwr_i | input | 1 | Global write: stores all four lanes |
| bwr_en_i | input | 1 | Enables the per-lane write selects |
| bsel_i | input | 4 | Per-lane write selects |
| oe_i | input | 1 | Asynchronous output enable, active high |
| sleep_i | input | 1 | Low-power request |
| dq_i | input | 36 | Write data, bus input side |
| dq_o | output | 36 | Read data, bus output side |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
A read presented before edge N produces a result two edges after it is presented: `dq_o` changes just after edge N+1, and `dq_oe_o` follows in the same cycle, masked or not according to the cycle accepted at edge N-1. A write presented before edge N becomes visible to a read accepted at edge N+1 or later. The bench keeps a reference pipeline of the same depth and updates it on each rising edge. It drives inputs at the falling edge and compares one time unit after the rising edge, when the model and the design have both moved to the same cycle. The checks on `oe_i` and `sleep_i` toggle those inputs in the middle of a cycle and sample half a time unit later, because these two inputs act without any clock edge.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

    localparam int LANES     = 4;
    localparam int LANE_DATA = 8;
    localparam int LANE_W    = LANE_DATA + 1;
    localparam int DATA_BITS = LANES * LANE_DATA;
    localparam int WORD_W    = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0]  lane_vec_t;

    // Registered control of one accepted cycle
    typedef struct packed {
        logic      sel;    // all chip selects active and not asleep
        logic      wr;     // write cycle (global or byte)
        lane_vec_t lanes;  // lanes to store on a write
    } cyc_ctl_t;

    function automatic logic chip_on(logic c1_n, logic c2, logic c3_n);
        return !c1_n && c2 && !c3_n;
    endfunction

    function automatic lane_vec_t lane_enables(logic gw, logic bwe, lane_vec_t bs);
        if (gw)
            return '1;
        else if (bwe)
            return bs;
        else
            return '0;
    endfunction

    function automatic lane_t lane_get(word_t w, int k);
        return {w[DATA_BITS + k], w[k*LANE_DATA +: LANE_DATA]};
    endfunction

endpackage

// File: rtl/psram_in_stage.sv
`timescale 1ns/1ps
module psram_in_stage
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              gwr_i,
    input  logic              bwr_en_i,
    input  lane_vec_t         bsel_i,
    input  logic              sleep_i,
    input  word_t             dq_i,
    output cyc_ctl_t          ctl_o,
    output logic              prev_sel_o,
    output logic [ADDR_W-1:0] addr_o,
    output word_t             wdata_o
);

    cyc_ctl_t ctl_d;

    always_comb begin
        ctl_d.sel   = chip_on(cs1_n_i, cs2_i, cs3_n_i) && !sleep_i;
        ctl_d.wr    = gwr_i || bwr_en_i;
        ctl_d.lanes = lane_enables(gwr_i, bwr_en_i, bsel_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o      <= '0;
            prev_sel_o <= 1'b0;
            addr_o     <= '0;
            wdata_o    <= '0;
        end else begin
            ctl_o      <= ctl_d;
            prev_sel_o <= ctl_o.sel;
            addr_o     <= addr_i;
            wdata_o    <= dq_i;
        end
    end

endmodule

// File: rtl/psram_array.sv
`timescale 1ns/1ps
module psram_array
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  lane_vec_t         wr_lanes_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    lane_t lane_rd [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes_i[k])
                mem[addr_i] <= lane_get(wdata_i, k);
        end

        assign lane_rd[k] = mem[addr_i];
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < LANES; k++) begin
            rdata_o[k*LANE_DATA +: LANE_DATA] = lane_rd[k][LANE_DATA-1:0];
            rdata_o[DATA_BITS + k]            = lane_rd[k][LANE_DATA];
        end
    end

endmodule

// File: rtl/psram_out_stage.sv
`timescale 1ns/1ps
module psram_out_stage
    import psram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en_i,
    input  logic  prev_sel_i,
    input  word_t rdata_i,
    input  logic  oe_i,
    input  logic  sleep_i,
    output word_t dq_o,
    output logic  dq_oe_o
);

    logic valid_q;
    logic first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_o    <= '0;
            valid_q <= 1'b0;
            first_q <= 1'b1;
        end else begin
            if (rd_en_i)
                dq_o <= rdata_i;
            valid_q <= rd_en_i;
            first_q <= !prev_sel_i;
        end
    end

    assign dq_oe_o = oe_i && valid_q && !first_q && !sleep_i;

endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              gwr_i,
    input  logic              bwr_en_i,
    input  logic [3:0]        bsel_i,
    input  logic              oe_i,
    input  logic              sleep_i,
    input  logic [35:0]       dq_i,
    output logic [35:0]       dq_o,
    output logic              dq_oe_o
);

    cyc_ctl_t          ctl_q;
    logic              prev_sel_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             wdata_q;
    word_t             rdata;
    lane_vec_t         wr_lanes;
    logic              rd_en;

    psram_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .cs1_n_i    (cs1_n_i),
        .cs2_i      (cs2_i),
        .cs3_n_i    (cs3_n_i),
        .gwr_i      (gwr_i),
        .bwr_en_i   (bwr_en_i),
        .bsel_i     (bsel_i),
        .sleep_i    (sleep_i),
        .dq_i       (dq_i),
        .ctl_o      (ctl_q),
        .prev_sel_o (prev_sel_q),
        .addr_o     (addr_q),
        .wdata_o    (wdata_q)
    );

    assign wr_lanes = (ctl_q.sel && ctl_q.wr) ? ctl_q.lanes : '0;
    assign rd_en    = ctl_q.sel && !ctl_q.wr;

    psram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .wr_lanes_i (wr_lanes),
        .addr_i     (addr_q),
        .wdata_i    (wdata_q),
        .rdata_o    (rdata)
    );

    psram_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .rd_en_i    (rd_en),
        .prev_sel_i (prev_sel_q),
        .rdata_i    (rdata),
        .oe_i       (oe_i),
        .sleep_i    (sleep_i),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o)
    );

endmodule

// File: rtl/pipe_sram_chk.sv
`timescale 1ns/1ps
module pipe_sram_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs1_n_i,
    input logic        cs2_i,
    input logic        cs3_n_i,
    input logic        gwr_i,
    input logic        bwr_en_i,
    input logic        oe_i,
    input logic        sleep_i,
    input logic [35:0] dq_o,
    input logic        dq_oe_o
);

    logic port_sel;
    logic port_rd;

    assign port_sel = !cs1_n_i && cs2_i && !cs3_n_i && !sleep_i;
    assign port_rd  = port_sel && !gwr_i && !bwr_en_i;

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_i |-> !dq_oe_o);

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !dq_oe_o);

    // R8
    drive_origin_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe_o |-> ($past(port_rd, 2) && $past(port_sel, 3)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(port_rd, 2) |-> $stable(dq_o));

endmodule

bind pipe_sram pipe_sram_chk u_chk (.*);

// File: tb/pipe_sram_tb.sv
`timescale 1ns/1ps
module pipe_sram_tb;

    localparam int AW = 6;

    localparam logic [2:0] OP_RD   = 3'd0;
    localparam logic [2:0] OP_BW   = 3'd1;
    localparam logic [2:0] OP_GW   = 3'd2;
    localparam logic [2:0] OP_DS   = 3'd3;
    localparam logic [2:0] OP_SLW  = 3'd4;
    localparam logic [2:0] OP_GWBS = 3'd5;

    localparam int NVEC = 17;
    // {op, addr, bsel, data}
    localparam logic [48:0] VEC [NVEC] = '{
        {OP_GW,   6'd1, 4'b0000, 36'h1_2345_6789},
        {OP_GW,   6'd2, 4'b1111, 36'hE_DCBA_9876},
        {OP_RD,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_RD,   6'd2, 4'b0000, 36'h0_0000_0000},
        {OP_BW,   6'd1, 4'b0101, 36'hF_AAAA_AAAA},
        {OP_RD,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_DS,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_RD,   6'd2, 4'b0000, 36'h0_0000_0000},
        {OP_RD,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_GWBS, 6'd3, 4'b0000, 36'h5_0F0F_0F0F},
        {OP_RD,   6'd3, 4'b0000, 36'h0_0000_0000},
        {OP_BW,   6'd3, 4'b0000, 36'hF_FFFF_FFFF},
        {OP_RD,   6'd3, 4'b0000, 36'h0_0000_0000},
        {OP_SLW,  6'd1, 4'b0000, 36'h0_1111_1111},
        {OP_RD,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_RD,   6'd1, 4'b0000, 36'h0_0000_0000},
        {OP_RD,   6'd2, 4'b0000, 36'h0_0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          cs1_n_i, cs2_i, cs3_n_i;
    logic          gwr_i, bwr_en_i;
    logic [3:0]    bsel_i;
    logic          oe_i, sleep_i;
    logic [35:0]   dq_i;
    logic [35:0]   dq_o;
    logic          dq_oe_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    pipe_sram #(.ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (addr_i),
        .cs1_n_i  (cs1_n_i),
        .cs2_i    (cs2_i),
        .cs3_n_i  (cs3_n_i),
        .gwr_i    (gwr_i),
        .bwr_en_i (bwr_en_i),
        .bsel_i   (bsel_i),
        .oe_i     (oe_i),
        .sleep_i  (sleep_i),
        .dq_i     (dq_i),
        .dq_o     (dq_o),
        .dq_oe_o  (dq_oe_o)
    );

    // Reference pipeline built from the requirements
    logic [35:0]   mm [1 << AW];
    logic          p_sel, p_wr, pp_sel;
    logic [3:0]    p_lanes;
    logic [AW-1:0] p_addr;
    logic [35:0]   p_data;
    logic [35:0]   m_out;
    logic          m_valid, m_first;

    always @(posedge clk) begin
        if (rst) begin
            p_sel <= 0; p_wr <= 0; pp_sel <= 0; p_lanes <= 0;
            p_addr <= 0; p_data <= 0;
            m_out <= 0; m_valid <= 0; m_first <= 1;
        end else begin
            if (p_sel && p_wr) begin
                for (int k = 0; k < 4; k++) begin
                    if (p_lanes[k]) begin
                        mm[p_addr][k*8 +: 8] <= p_data[k*8 +: 8];
                        mm[p_addr][32+k]     <= p_data[32+k];
                    end
                end
            end
            if (p_sel && !p_wr)
                m_out <= mm[p_addr];
            m_valid <= p_sel && !p_wr;
            m_first <= !pp_sel;
            pp_sel  <= p_sel;
            p_sel   <= !cs1_n_i && cs2_i && !cs3_n_i && !sleep_i;
            p_wr    <= gwr_i || bwr_en_i;
            p_lanes <= gwr_i ? 4'hF : (bwr_en_i ? bsel_i : 4'h0);
            p_addr  <= addr_i;
            p_data  <= dq_i;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [3:0] bs, input logic [35:0] d);
        @(negedge clk);
        addr_i = a; bsel_i = bs; dq_i = d;
        cs1_n_i = 0; cs2_i = 1; cs3_n_i = 0;
        gwr_i = 0; bwr_en_i = 0; sleep_i = 0;
        case (op)
            OP_BW:   bwr_en_i = 1;
            OP_GW:   gwr_i = 1;
            OP_DS:   cs2_i = 0;
            OP_SLW:  begin sleep_i = 1; gwr_i = 1; end
            OP_GWBS: begin gwr_i = 1; bwr_en_i = 1; end
            default: ;
        endcase
    endtask

    // One cycle, then compare outputs against the reference pipeline
    task automatic step(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [3:0] bs, input logic [35:0] d, input string req);
        logic exp_oe;
        drive(op, a, bs, d);
        @(posedge clk);
        #1;
        exp_oe = oe_i && m_valid && !m_first && !sleep_i;
        chk(dq_oe_o === exp_oe, {req, "/R8 driver enable"}, {35'd0, dq_oe_o}, {35'd0, exp_oe});
        chk(dq_o === m_out, {req, "/R1 read data"}, dq_o, m_out);
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            OP_RD:   return "R5";
            OP_BW:   return "R3";
            OP_GW:   return "R4";
            OP_DS:   return "R6";
            OP_SLW:  return "R9";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        rst = 1; oe_i = 1; sleep_i = 0;
        addr_i = 0; cs1_n_i = 1; cs2_i = 0; cs3_n_i = 1;
        gwr_i = 0; bwr_en_i = 0; bsel_i = 0; dq_i = 0;
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        chk(dq_o === 36'd0, "R10 output register", dq_o, 36'd0);
        chk(dq_oe_o === 1'b0, "R10 driver enable", {35'd0, dq_oe_o}, 36'd0);
        @(negedge clk);
        rst = 0;

        for (int i = 0; i < NVEC; i++)
            step(VEC[i][48:46], VEC[i][45:40], VEC[i][39:36], VEC[i][35:0],
                 op_req(VEC[i][48:46]));
        for (int i = 0; i < 3; i++)
            step(OP_DS, 6'd0, 4'd0, 36'd0, "R6");

        // R2: lane 2 written alone lands on bits 23:16 and bit 34
        step(OP_GW, 6'd4, 4'd0, 36'd0, "R4");
        step(OP_BW, 6'd4, 4'b0100, 36'hF_FFFF_FFFF, "R3");
        step(OP_RD, 6'd4, 4'd0, 36'd0, "R5");
        step(OP_DS, 6'd0, 4'd0, 36'd0, "R6");
        chk(dq_o === 36'h4_00FF_0000, "R2 lane placement", dq_o, 36'h4_00FF_0000);

        // R8: read after deselect is masked, the following one drives
        step(OP_RD, 6'd4, 4'd0, 36'd0, "R8");
        step(OP_RD, 6'd4, 4'd0, 36'd0, "R8");
        chk(dq_oe_o === 1'b0, "R8 masked first read", {35'd0, dq_oe_o}, 36'd0);
        step(OP_DS, 6'd0, 4'd0, 36'd0, "R8");
        chk(dq_oe_o === 1'b1, "R8 second read drives", {35'd0, dq_oe_o}, 36'd1);

        // R7: output enable acts without a clock edge
        oe_i = 0;
        #0.5;
        chk(dq_oe_o === 1'b0, "R7 oe low", {35'd0, dq_oe_o}, 36'd0);
        oe_i = 1;
        #0.5;
        chk(dq_oe_o === 1'b1, "R7 oe high", {35'd0, dq_oe_o}, 36'd1);

        // R9: sleep turns the driver off at once
        step(OP_RD, 6'd1, 4'd0, 36'd0, "R9");
        step(OP_RD, 6'd1, 4'd0, 36'd0, "R9");
        step(OP_DS, 6'd0, 4'd0, 36'd0, "R9");
        chk(dq_oe_o === 1'b1, "R9 driving before sleep", {35'd0, dq_oe_o}, 36'd1);
        sleep_i = 1;
        #0.5;
        chk(dq_oe_o === 1'b0, "R9 sleep driver off", {35'd0, dq_oe_o}, 36'd0);
        sleep_i = 0;
        // R9/R5: word 1 still holds its pre-sleep contents
        chk(dq_o === mm[1], "R9 contents kept", dq_o, mm[1]);

        step(OP_DS, 6'd0, 4'd0, 36'd0, "R6");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule